// File: doc/BRIEF.md
# OTP Fuse Controller with Shadow Registers

This block controls a one-time-programmable fuse array through a 32-bit register bus. Every fuse word has a shadow register that software reads. The fuse array itself is never read directly. Software first asks for array power and waits for the powered status bit. It then writes a control word that carries a word index and two operation flags. The flags start one of three operations: reload the word into its shadow, burn the write-data value into the word, or burn that word's permanent-lock fuse.

Each accepted operation holds the busy status bit for a fixed number of cycles. The result then appears in the shadow register, in the fuse array, or in the fail status bit. Per-word error and disturbed flags are packed 32 to a register. A `fuse_bad` input marks defective words so that error paths can be reached.

One sequencer drives the power handshake and the command timing through five states:
- `ST_OFF`: unpowered. It goes to `ST_PWRUP` when the power request is set.
- `ST_PWRUP`: powering up. It falls back to `ST_OFF` if the request drops, and reaches `ST_READY` after `PWR_DELAY` cycles.
- `ST_READY`: idle and powered. It goes to `ST_BUSY` when a command is accepted, and to `ST_PWRDN` when the request drops.
- `ST_BUSY`: command running. It returns to `ST_READY` after `BUSY_CYCLES` cycles, and the command takes effect on that last cycle.
- `ST_PWRDN`: powering down. It goes to `ST_OFF` after `PWR_DELAY` cycles.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Status bit 5 (powered) rises exactly `PWR_DELAY`+1 cycles after configuration bit 0 (at 0x000) is written to 1. It falls `PWR_DELAY`+1 cycles after that bit is written to 0.
- R2: A control write (0x004) is ignored while the array is unpowered or while busy is set. Busy stays low, and no fuse or shadow word changes.
- R3: An accepted command holds status bit 3 (busy) for exactly `BUSY_CYCLES` cycles.
- R4: The control word carries the word index in bits [IDX_W-1:0]. With bit 8 clear, the command is a reload: it copies fuse word n into its shadow, which reads at 0x200+4*n.
- R5: With bit 8 set and bit 9 clear, the command is a program: it ORs the write-data register (0x008) into fuse word n. Status bit 4 (fail) is clear after a program whose read-back holds every requested bit.
- R6: A bus write to shadow n changes only the shadow. A later reload restores the fuse value.
- R7: Word n owns bit n%32 of the register at 0x034+4*(n/32) (error) and of the register at 0x01C+4*(n/32) (disturbed). A reload of a word marked in `fuse_bad` sets its error bit. A failed program sets its disturbed bit and sets fail. Bus writes never clear error bits.
- R8: With bits 8 and 9 both set, the command burns the permanent-lock fuse of word n. For n < `UPPER_START` the lock fuse word is n>>3 and the pattern is 3<<(2*(n&7)). For higher n the lock fuse word is (n>>4)+2 and the pattern is 1<<(n&15). Lock fuse word k reads at 0x100+4*k. Programming a word with any of its lock bits set fails.
- R9: Global lock register 0x010 bits only set and never clear. Bit 3 makes every program and lock-fuse command fail. Bit 0 makes programs of words at or above `UPPER_START` fail.
- R10: The debug configuration register (0x014, `DBG_W` bits) is writable until global lock bit 2 is set. After that, writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when set together with bus_en |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fuse_bad | input | NUM_WORDS | Marks defective fuse words |

## Verification
The bench builds the block with 64 words, an upper region starting at word 32, an 8-cycle busy time and a 4-cycle power delay. With these values the error and disturbed flags span two banks, so a flag in the second bank (word 40) checks the bank stride. Word 10 and word 50 fall on either side of the region boundary, so both lock address and pattern formulas are checked against computed values. The short delays let the bench count the exact power-up, power-down and busy cycles.

// File: rtl/otpc_pkg.sv
package otpc_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PWRUP,
        ST_READY,
        ST_BUSY,
        ST_PWRDN
    } otpc_state_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_PROG,
        OP_LOCK
    } otpc_op_e;

    localparam int DBG_W      = 11;
    localparam int OFF_CONF   = 'h000;
    localparam int OFF_CTRL   = 'h004;
    localparam int OFF_WDATA  = 'h008;
    localparam int OFF_STAT   = 'h00C;
    localparam int OFF_GLOCK  = 'h010;
    localparam int OFF_DEBUG  = 'h014;
    localparam int DIST_BASE  = 'h01C;
    localparam int ERR_BASE   = 'h034;
    localparam int PLOCK_BASE = 'h100;

endpackage

// File: rtl/otpc_seq.sv
module otpc_seq
    import otpc_pkg::*;
#(
    parameter int PWR_DELAY   = 4,
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req,
    input  logic cmd_req,
    output logic accept,
    output logic done,
    output logic busy,
    output logic powered
);
    localparam int MAXC  = (PWR_DELAY > BUSY_CYCLES) ? PWR_DELAY : BUSY_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    otpc_state_e state_q, state_n;
    logic [CNT_W-1:0] cnt_q;
    logic pwr_last, busy_last;

    assign pwr_last  = (cnt_q == CNT_W'(PWR_DELAY - 1));
    assign busy_last = (cnt_q == CNT_W'(BUSY_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= (state_n != state_q) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF:   if (pwr_req) state_n = ST_PWRUP;
            ST_PWRUP: begin
                if (!pwr_req)      state_n = ST_OFF;
                else if (pwr_last) state_n = ST_READY;
            end
            ST_READY: begin
                if (cmd_req)       state_n = ST_BUSY;
                else if (!pwr_req) state_n = ST_PWRDN;
            end
            ST_BUSY:  if (busy_last) state_n = ST_READY;
            ST_PWRDN: if (pwr_last)  state_n = ST_OFF;
            default:  state_n = ST_OFF;
        endcase
    end

    always_comb begin
        accept  = (state_q == ST_READY) && cmd_req;
        done    = (state_q == ST_BUSY) && busy_last;
        busy    = (state_q == ST_BUSY);
        powered = (state_q == ST_READY) || (state_q == ST_BUSY) || (state_q == ST_PWRDN);
    end

endmodule

// File: rtl/otpc_lockmap.sv
module otpc_lockmap #(
    parameter int NUM_WORDS   = 64,
    parameter int UPPER_START = 32,
    parameter int IDX_W       = 6,
    parameter int LA_W        = 3
) (
    input  logic [IDX_W-1:0] idx,
    output logic [LA_W-1:0]  addr,
    output logic [31:0]      pattern
);
    always_comb begin
        if (int'(idx) < UPPER_START) begin
            addr    = LA_W'(idx >> 3);
            pattern = 32'h3 << {idx[2:0], 1'b0};
        end else begin
            addr    = LA_W'((idx >> 4) + IDX_W'(2));
            pattern = 32'h1 << idx[3:0];
        end
    end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otpc_pkg::*;
#(
    parameter int NUM_WORDS   = 64,
    parameter int UPPER_START = 32,
    parameter int BUSY_CYCLES = 8,
    parameter int PWR_DELAY   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_WORDS-1:0] fuse_bad
);
    localparam int IDX_W      = $clog2(NUM_WORDS);
    localparam int BANKS      = NUM_WORDS / 32;
    localparam int LOCK_WORDS = ((NUM_WORDS - 1) >> 4) + 3;
    localparam int LA_W       = $clog2(LOCK_WORDS);

    logic                            conf_q, fail_q;
    logic [31:0]                     wdata_q, cdata_q;
    logic [3:0]                      glock_q;
    logic [DBG_W-1:0]                dbg_q;
    logic [NUM_WORDS-1:0][31:0]      fuse_q;
    logic [NUM_WORDS-1:0][31:0]      shadow_q;
    logic [LOCK_WORDS-1:0][31:0]     plock_q;
    logic [NUM_WORDS-1:0]            err_q, dist_q;
    logic [IDX_W-1:0]                idx_q;
    otpc_op_e                        op_q;

    logic wr, cmd_req, accept, done, busy, powered;
    logic [LA_W-1:0] lk_addr;
    logic [31:0]     lk_pat;
    logic            word_locked, prog_block, prog_fail, lock_fail;
    logic [31:0]     rd;

    assign wr      = bus_en && bus_we;
    assign cmd_req = wr && (bus_addr == 12'(OFF_CTRL));

    otpc_seq #(.PWR_DELAY(PWR_DELAY), .BUSY_CYCLES(BUSY_CYCLES)) seq_i (
        .clk(clk), .rst_n(rst_n), .pwr_req(conf_q), .cmd_req(cmd_req),
        .accept(accept), .done(done), .busy(busy), .powered(powered)
    );

    otpc_lockmap #(.NUM_WORDS(NUM_WORDS), .UPPER_START(UPPER_START),
                   .IDX_W(IDX_W), .LA_W(LA_W)) map_i (
        .idx(idx_q), .addr(lk_addr), .pattern(lk_pat)
    );

    always_comb begin
        word_locked = |(plock_q[lk_addr] & lk_pat);
        prog_block  = glock_q[3] || (glock_q[0] && int'(idx_q) >= UPPER_START)
                      || word_locked || fuse_bad[idx_q];
        prog_fail   = prog_block && ((fuse_q[idx_q] & cdata_q) != cdata_q);
        lock_fail   = glock_q[3] && ((plock_q[lk_addr] & lk_pat) != lk_pat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conf_q   <= 1'b0;
            fail_q   <= 1'b0;
            wdata_q  <= '0;
            cdata_q  <= '0;
            glock_q  <= '0;
            dbg_q    <= '0;
            fuse_q   <= '0;
            shadow_q <= '0;
            plock_q  <= '0;
            err_q    <= '0;
            dist_q   <= '0;
            idx_q    <= '0;
            op_q     <= OP_READ;
        end else begin
            if (wr) begin
                if (bus_addr == 12'(OFF_CONF))  conf_q  <= bus_wdata[0];
                if (bus_addr == 12'(OFF_WDATA)) wdata_q <= bus_wdata;
                if (bus_addr == 12'(OFF_GLOCK)) glock_q <= glock_q | (bus_wdata[3:0] & 4'b1101);
                if (bus_addr == 12'(OFF_DEBUG) && !glock_q[2]) dbg_q <= bus_wdata[DBG_W-1:0];
                if (bus_addr[11:9] == 3'b001 && int'(bus_addr[8:2]) < NUM_WORDS)
                    shadow_q[bus_addr[IDX_W+1:2]] <= bus_wdata;
            end
            if (accept) begin
                idx_q   <= bus_wdata[IDX_W-1:0];
                cdata_q <= wdata_q;
                op_q    <= !bus_wdata[8] ? OP_READ : (bus_wdata[9] ? OP_LOCK : OP_PROG);
            end
            if (done) begin
                unique case (op_q)
                    OP_READ: begin
                        shadow_q[idx_q] <= fuse_q[idx_q];
                        if (fuse_bad[idx_q]) err_q[idx_q] <= 1'b1;
                        fail_q <= 1'b0;
                    end
                    OP_PROG: begin
                        if (!prog_block) fuse_q[idx_q] <= fuse_q[idx_q] | cdata_q;
                        if (prog_fail)   dist_q[idx_q] <= 1'b1;
                        fail_q <= prog_fail;
                    end
                    OP_LOCK: begin
                        if (!glock_q[3]) plock_q[lk_addr] <= plock_q[lk_addr] | lk_pat;
                        fail_q <= lock_fail;
                    end
                    default: fail_q <= 1'b0;
                endcase
            end
        end
    end

    always_comb begin
        rd = '0;
        case (bus_addr)
            12'(OFF_CONF):  rd = {31'b0, conf_q};
            12'(OFF_WDATA): rd = wdata_q;
            12'(OFF_STAT):  rd = {26'b0, powered, fail_q, busy, 3'b0};
            12'(OFF_GLOCK): rd = {28'b0, glock_q};
            12'(OFF_DEBUG): rd = {{(32-DBG_W){1'b0}}, dbg_q};
            default:        rd = '0;
        endcase
        for (int b = 0; b < BANKS; b++) begin
            if (bus_addr == 12'(DIST_BASE + 4*b)) rd = dist_q[b*32 +: 32];
            if (bus_addr == 12'(ERR_BASE + 4*b))  rd = err_q[b*32 +: 32];
        end
        for (int k = 0; k < LOCK_WORDS; k++)
            if (bus_addr == 12'(PLOCK_BASE + 4*k)) rd = plock_q[k];
        if (bus_addr[11:9] == 3'b001 && int'(bus_addr[8:2]) < NUM_WORDS)
            rd = shadow_q[bus_addr[IDX_W+1:2]];
    end

    assign bus_rdata = rd;

endmodule

// File: rtl/otpc_checker.sv
module otpc_checker #(
    parameter int NUM_WORDS   = 64,
    parameter int LOCK_WORDS  = 6,
    parameter int BUSY_CYCLES = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      pwr_req,
    input logic                      powered,
    input logic                      busy,
    input logic                      accept,
    input logic [NUM_WORDS*32-1:0]   fuse_bits,
    input logic [LOCK_WORDS*32-1:0]  plock_bits,
    input logic [NUM_WORDS-1:0]      err_bits,
    input logic [3:0]                glock
);
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 16'd1;
        else           run_q <= '0;
    end

    p_power_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered) |-> pwr_req);

    p_busy_needs_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> powered);

    p_accept_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    p_busy_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 16'(BUSY_CYCLES)));

    p_fuse_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((fuse_bits & $past(fuse_bits)) == $past(fuse_bits)));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_bits & $past(err_bits)) == $past(err_bits)));

    p_plock_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((plock_bits & $past(plock_bits)) == $past(plock_bits)));

    p_glock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((glock & $past(glock)) == $past(glock)));

endmodule

bind otp_fuse_ctrl otpc_checker #(
    .NUM_WORDS(NUM_WORDS), .LOCK_WORDS(LOCK_WORDS), .BUSY_CYCLES(BUSY_CYCLES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .pwr_req(conf_q), .powered(powered), .busy(busy),
    .accept(accept), .fuse_bits(fuse_q), .plock_bits(plock_q), .err_bits(err_q),
    .glock(glock_q)
);

// File: tb/otp_fuse_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb_top;
    localparam int NW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NW-1:0] fuse_bad = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    otp_fuse_ctrl #(.NUM_WORDS(NW), .UPPER_START(32), .BUSY_CYCLES(8), .PWR_DELAY(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_bad(fuse_bad)
    );

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [31:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    task automatic push_val(input logic [31:0] act, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        act_q.push_back(act);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
        #1 v = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic check_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        logic [31:0] v;
        rd(a, v);
        push_val(v, e, t);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_en = 1'b1; bus_we = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        do rd(12'h00C, v); while (v[3]);
    endtask

    task automatic cmd(input logic [31:0] c);
        wr(12'h004, c);
        wait_idle();
    endtask

    task automatic count_while(input int bitn, input logic lvl, output int n);
        n = 0;
        bus_addr = 12'h00C;
        #1;
        while (bus_rdata[bitn] == lvl && n < 1000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        fuse_bad = '0;
        fuse_bad[5]  = 1'b1;
        fuse_bad[40] = 1'b1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset state
        check_rd(12'h00C, 32'h0, "reset status");
        check_rd(12'h200, 32'h0, "reset shadow R4");
        check_rd(12'h034, 32'h0, "reset error R7");

        // R2: command while unpowered is ignored
        wr(12'h008, 32'hA5);
        wr(12'h004, 32'h103);
        check_rd(12'h00C, 32'h0, "R2 unpowered ignore busy");

        // R1 power-up timing
        wr(12'h000, 32'h1);
        count_while(5, 1'b0, n);
        push_val(n, 5, "R1 power-up delay");
        cmd(32'h003);
        check_rd(12'h20C, 32'h0, "R2 unpowered program left fuse");

        // R3/R5 program and busy length
        wr(12'h008, 32'h0000_00A5);
        wr(12'h004, 32'h103);
        count_while(3, 1'b1, n);
        push_val(n, 8, "R3 busy cycles");
        check_rd(12'h00C, 32'h20, "R5 status no fail");
        cmd(32'h003);
        check_rd(12'h20C, 32'hA5, "R4 reload word 3");
        wr(12'h008, 32'h0F00);
        cmd(32'h103);
        cmd(32'h003);
        check_rd(12'h20C, 32'h0FA5, "R5 OR program");

        // R2 busy ignore
        wr(12'h008, 32'h22);
        wr(12'h004, 32'h104);
        wr(12'h004, 32'h107);
        wait_idle();
        cmd(32'h004);
        cmd(32'h007);
        check_rd(12'h210, 32'h22, "R2 first command done");
        check_rd(12'h21C, 32'h0, "R2 busy command ignored");

        // R6 shadow direct write
        wr(12'h210, 32'hDEAD);
        check_rd(12'h210, 32'hDEAD, "R6 shadow write");
        cmd(32'h004);
        check_rd(12'h210, 32'h22, "R6 fuse unchanged");

        // R7 error/disturbed
        cmd(32'h005);
        check_rd(12'h034, 32'h20, "R7 error bank0 bit5");
        wr(12'h008, 32'h1);
        cmd(32'h128);
        check_rd(12'h00C, 32'h30, "R7 program fail status");
        check_rd(12'h020, 32'h100, "R7 disturbed bank1 bit8");
        check_rd(12'h038, 32'h0, "R7 error bank1 clear");
        wr(12'h034, 32'h0);
        check_rd(12'h034, 32'h20, "R7 error sticky");

        // R8 permanent lock
        cmd(32'h30A);
        check_rd(12'h104, 32'h30, "R8 lower lock word/pattern");
        wr(12'h008, 32'h1);
        cmd(32'h10A);
        check_rd(12'h00C, 32'h30, "R8 locked word fail");
        cmd(32'h00A);
        check_rd(12'h228, 32'h0, "R8 locked word unchanged");
        cmd(32'h332);
        check_rd(12'h114, 32'h4, "R8 upper lock word/pattern");

        // R9 global lock
        wr(12'h010, 32'h1);
        wr(12'h008, 32'h7);
        cmd(32'h121);
        check_rd(12'h00C, 32'h30, "R9 upper programming blocked");
        cmd(32'h021);
        check_rd(12'h284, 32'h0, "R9 upper word unchanged");
        wr(12'h008, 32'h9);
        cmd(32'h10C);
        check_rd(12'h00C, 32'h20, "R9 lower programming allowed");
        cmd(32'h00C);
        check_rd(12'h230, 32'h9, "R9 lower word programmed");
        wr(12'h010, 32'h8);
        wr(12'h010, 32'h0);
        check_rd(12'h010, 32'h9, "R9 global lock sticky");
        wr(12'h008, 32'h10);
        cmd(32'h10C);
        check_rd(12'h00C, 32'h30, "R9 all programming blocked");
        cmd(32'h00C);
        check_rd(12'h230, 32'h9, "R9 word kept");
        cmd(32'h314);
        check_rd(12'h00C, 32'h30, "R9 lock command blocked");
        check_rd(12'h108, 32'h0, "R9 lock fuse unchanged");

        // R10 debug lock
        wr(12'h014, 32'h5);
        check_rd(12'h014, 32'h5, "R10 debug write");
        wr(12'h010, 32'h4);
        wr(12'h014, 32'h7FF);
        check_rd(12'h014, 32'h5, "R10 debug locked");

        // R1 power-down timing
        wr(12'h000, 32'h0);
        count_while(5, 1'b1, n);
        push_val(n, 5, "R1 power-down delay");
        check_rd(12'h00C, 32'h10, "R1 unpowered status");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule